// File: doc/BRIEF.md
# Selector-Based Logic Cell with Programmable Input Inversion

This block is a combinational logic cell with no truth-table memory. It holds two selectors. A quad selector picks one of four data inputs using two select bits. An octal selector picks one of eight data inputs using three select bits. Every data input of both selectors first passes through its own inverter. A static configuration bit turns each inverter on or off. The configuration word has one bit per data input, and the cell does not load it.

The octal selector is built from two four-way halves that share the two low select bits, followed by a two-way stage. A mode input controls that last stage. When the mode input is high, the cell uses the third select bit and drives both half outputs on their own tap pins. When the mode input is low, the top stage stays on the lower half and the taps are held at zero.

To build a lookup function, the integrator ties every data input of a selector to logic 1. The function inputs go on the select pins, and the function's truth table goes into the inversion bits. The output for select value s is then the complement of inversion bit s. A one- or two-input function fits on the quad selector or on either half. A three-input function fits only on the octal selector.

Top module: `mux_logic_cell`

## Requirements
- R1: `small_out` equals `small_data[small_sel]` XOR `small_inv[small_sel]` in the same cycle that the inputs change.
- R2: With `tbs` = 1, `big_out` equals `big_data[big_sel]` XOR `big_inv[big_sel]`. Select value s uses data and inversion bit index s.
- R3: With `tbs` = 0, `big_out` equals `big_data[i]` XOR `big_inv[i]` with i = `{1'b0, big_sel[1:0]}`. `big_sel[2]` and the upper four data and inversion bits have no effect on it.
- R4: With `tbs` = 1, `tap_lo` equals the conditioned bit at index `big_sel[1:0]` (indices 0..3). `tap_hi` equals the conditioned bit at index 4 + `big_sel[1:0]`.
- R5: With `tbs` = 0, `tap_lo` and `tap_hi` are both 0, whatever the other inputs are.
- R6: With all eight `big_data` bits at 1 and `tbs` = 1, `big_out` = NOT `big_inv[big_sel]`. This holds for all 256 three-input functions held in `big_inv`.
- R7: With all four `small_data` bits at 1, `small_out` = NOT `small_inv[small_sel]` for all 16 two-input functions. With all eight `big_data` bits at 1 and `tbs` = 1, each tap gives NOT of its half's inversion bit in the same way.
- R8: A set inversion bit changes the output only when its own input is the one selected. Flipping an unselected input's inversion bit leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| small_data | input | 4 | Data inputs of the quad selector |
| small_sel | input | 2 | Select bits of the quad selector |
| small_inv | input | 4 | Inversion bits of the quad selector inputs, 1 = invert |
| big_data | input | 8 | Data inputs of the octal selector |
| big_sel | input | 3 | Select bits of the octal selector; bits 1:0 drive both halves |
| big_inv | input | 8 | Inversion bits of the octal selector inputs, 1 = invert |
| tbs | input | 1 | Top-stage mode: 1 = full eight-way and taps active |
| small_out | output | 1 | Quad selector result |
| big_out | output | 1 | Octal selector result |
| tap_lo | output | 1 | Lower half result when `tbs` = 1, else 0 |
| tap_hi | output | 1 | Upper half result when `tbs` = 1, else 0 |

## Verification
The cell holds no state, so any fault in the inverter banks, the halves or the top stage shows up on an output at once. It is visible in the same cycle as the input pattern that selects the faulty path. A wrong inversion polarity or a swapped index is exposed by the three-input function sweep, because each of the 256 configurations is read at all eight select values. A mode-gating fault shows up on the taps or on `big_out` as soon as `tbs` is low with `big_sel[2]` set.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    // Default select widths of the two selectors
    localparam int unsigned QUAD_SEL_W  = 2;
    localparam int unsigned OCTAL_SEL_W = 3;

    // Behaviour of the octal selector's final stage
    typedef enum logic {
        TOP_LOW_ONLY = 1'b0,   // final stage parked on lower half, taps off
        TOP_FULL     = 1'b1    // final stage follows top select, taps live
    } mlc_top_mode_e;

    // The two half results of the octal selector
    typedef struct packed {
        logic hi;
        logic lo;
    } mlc_tap_t;

    // Static polarity control of a single input
    function automatic logic mlc_condition(input logic raw, input logic flip);
        return flip ? ~raw : raw;
    endfunction

    // Map the raw mode pin onto the enum
    function automatic mlc_top_mode_e mlc_decode_mode(input logic pin);
        return pin ? TOP_FULL : TOP_LOW_ONLY;
    endfunction

endpackage

// File: rtl/mlc_inv_bank.sv
module mlc_inv_bank #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] raw_in,
    input  logic [WIDTH-1:0] flip_cfg,
    output logic [WIDTH-1:0] cond_out
);
    import mlc_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign cond_out[i] = mlc_condition(raw_in[i], flip_cfg[i]);
    end

endmodule

// File: rtl/mlc_selector.sv
module mlc_selector #(
    parameter int unsigned SEL_W = 2
) (
    input  logic [(1<<SEL_W)-1:0] din,
    input  logic [SEL_W-1:0]      sel,
    output logic                  dout
);
    localparam int unsigned LEAVES = 1 << SEL_W;

    // Binary reduction tree: level k has LEAVES >> k nodes
    logic [LEAVES-1:0] level [SEL_W+1];

    assign level[0] = din;

    for (genvar k = 0; k < SEL_W; k++) begin : g_lvl
        localparam int unsigned NODES = LEAVES >> (k + 1);
        for (genvar n = 0; n < NODES; n++) begin : g_node
            assign level[k+1][n] = sel[k] ? level[k][2*n+1] : level[k][2*n];
        end
        for (genvar z = NODES; z < LEAVES; z++) begin : g_pad
            assign level[k+1][z] = 1'b0;
        end
    end

    assign dout = level[SEL_W][0];

endmodule

// File: rtl/mlc_octal_mux.sv
module mlc_octal_mux #(
    parameter int unsigned SEL_W = 3
) (
    input  logic [(1<<SEL_W)-1:0] cond_in,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  mode_pin,
    output logic                  dout,
    output logic                  tap_lo,
    output logic                  tap_hi
);
    import mlc_pkg::*;

    localparam int unsigned HALF_W   = SEL_W - 1;
    localparam int unsigned HALF_LEN = 1 << HALF_W;

    mlc_top_mode_e mode;
    mlc_tap_t      halves;
    logic [1:0]    half_res;
    logic          top_sel;

    assign mode = mlc_decode_mode(mode_pin);

    for (genvar h = 0; h < 2; h++) begin : g_half
        mlc_selector #(.SEL_W(HALF_W)) u_half (
            .din  (cond_in[h*HALF_LEN +: HALF_LEN]),
            .sel  (sel[HALF_W-1:0]),
            .dout (half_res[h])
        );
    end

    assign top_sel = (mode == TOP_FULL) ? sel[SEL_W-1] : 1'b0;

    mlc_selector #(.SEL_W(1)) u_top (
        .din  (half_res),
        .sel  (top_sel),
        .dout (dout)
    );

    always_comb begin
        halves = '0;
        if (mode == TOP_FULL) begin
            halves.lo = half_res[0];
            halves.hi = half_res[1];
        end
    end

    assign tap_lo = halves.lo;
    assign tap_hi = halves.hi;

endmodule

// File: rtl/mux_logic_cell.sv
module mux_logic_cell #(
    parameter int unsigned SMALL_SEL_W = mlc_pkg::QUAD_SEL_W,
    parameter int unsigned BIG_SEL_W   = mlc_pkg::OCTAL_SEL_W,
    localparam int unsigned SMALL_N    = 1 << SMALL_SEL_W,
    localparam int unsigned BIG_N      = 1 << BIG_SEL_W
) (
    input  logic [SMALL_N-1:0]     small_data,
    input  logic [SMALL_SEL_W-1:0] small_sel,
    input  logic [SMALL_N-1:0]     small_inv,
    input  logic [BIG_N-1:0]       big_data,
    input  logic [BIG_SEL_W-1:0]   big_sel,
    input  logic [BIG_N-1:0]       big_inv,
    input  logic                   tbs,
    output logic                   small_out,
    output logic                   big_out,
    output logic                   tap_lo,
    output logic                   tap_hi
);
    logic [SMALL_N-1:0] small_cond;
    logic [BIG_N-1:0]   big_cond;

    mlc_inv_bank #(.WIDTH(SMALL_N)) u_small_inv (
        .raw_in   (small_data),
        .flip_cfg (small_inv),
        .cond_out (small_cond)
    );

    mlc_inv_bank #(.WIDTH(BIG_N)) u_big_inv (
        .raw_in   (big_data),
        .flip_cfg (big_inv),
        .cond_out (big_cond)
    );

    mlc_selector #(.SEL_W(SMALL_SEL_W)) u_small_sel (
        .din  (small_cond),
        .sel  (small_sel),
        .dout (small_out)
    );

    mlc_octal_mux #(.SEL_W(BIG_SEL_W)) u_big (
        .cond_in  (big_cond),
        .sel      (big_sel),
        .mode_pin (tbs),
        .dout     (big_out),
        .tap_lo   (tap_lo),
        .tap_hi   (tap_hi)
    );

endmodule

// File: rtl/mux_logic_cell_chk.sv
module mux_logic_cell_chk #(
    parameter int unsigned SMALL_SEL_W = 2,
    parameter int unsigned BIG_SEL_W   = 3,
    localparam int unsigned SMALL_N    = 1 << SMALL_SEL_W,
    localparam int unsigned BIG_N      = 1 << BIG_SEL_W,
    localparam int unsigned HALF_LEN   = BIG_N / 2
) (
    input logic [SMALL_N-1:0]     small_data,
    input logic [SMALL_SEL_W-1:0] small_sel,
    input logic [SMALL_N-1:0]     small_inv,
    input logic [BIG_N-1:0]       big_data,
    input logic [BIG_SEL_W-1:0]   big_sel,
    input logic [BIG_N-1:0]       big_inv,
    input logic                   tbs,
    input logic                   small_out,
    input logic                   big_out,
    input logic                   tap_lo,
    input logic                   tap_hi
);
    logic inputs_known;
    logic [BIG_SEL_W-2:0] low_idx;

    assign inputs_known = !$isunknown({small_data, small_sel, small_inv,
                                       big_data, big_sel, big_inv, tbs});
    assign low_idx = big_sel[BIG_SEL_W-2:0];

    always_comb begin
        if (inputs_known) begin
            // R1
            small_path_chk: assert (small_out ==
                (small_data[small_sel] != small_inv[small_sel]))
                else $error("small_out mismatch");
            // R5
            tap_gate_chk: assert (tbs || (!tap_lo && !tap_hi))
                else $error("taps live while mode low");
            // R2
            full_top_chk: assert (!tbs || big_out == (big_sel[BIG_SEL_W-1] ? tap_hi : tap_lo))
                else $error("top stage disagrees with taps");
            // R3
            low_only_chk: assert (tbs || big_out ==
                (big_data[low_idx] != big_inv[low_idx]))
                else $error("big_out not from lower half");
            // R4
            tap_hi_chk: assert (!tbs || tap_hi ==
                (big_data[HALF_LEN + low_idx] != big_inv[HALF_LEN + low_idx]))
                else $error("upper tap mismatch");
        end
    end

endmodule

bind mux_logic_cell mux_logic_cell_chk #(
    .SMALL_SEL_W (SMALL_SEL_W),
    .BIG_SEL_W   (BIG_SEL_W)
) u_chk (.*);

// File: tb/tb_mux_logic_cell.sv
module tb_mux_logic_cell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] small_data = '0;
    logic [1:0] small_sel  = '0;
    logic [3:0] small_inv  = '0;
    logic [7:0] big_data   = '0;
    logic [2:0] big_sel    = '0;
    logic [7:0] big_inv    = '0;
    logic       tbs        = 1'b0;
    logic       small_out, big_out, tap_lo, tap_hi;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    mux_logic_cell dut (
        .small_data (small_data),
        .small_sel  (small_sel),
        .small_inv  (small_inv),
        .big_data   (big_data),
        .big_sel    (big_sel),
        .big_inv    (big_inv),
        .tbs        (tbs),
        .small_out  (small_out),
        .big_out    (big_out),
        .tap_lo     (tap_lo),
        .tap_hi     (tap_hi)
    );

    // Behavioural reference built on integer arithmetic
    function automatic int bit_of(input int word, input int idx);
        return (word >> idx) & 1;
    endfunction

    function automatic int ref_small();
        return bit_of(int'(small_data), int'(small_sel)) ^ bit_of(int'(small_inv), int'(small_sel));
    endfunction

    function automatic int ref_big_at(input int idx);
        return bit_of(int'(big_data), idx) ^ bit_of(int'(big_inv), idx);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (sd=%b ss=%0d si=%b bd=%b bs=%0d bi=%b tbs=%0d)",
                     req, act, exp, small_data, small_sel, small_inv,
                     big_data, big_sel, big_inv, tbs);
        end
    endtask

    // Compare every output against the reference model
    task automatic compare_all();
        int lo_idx;
        lo_idx = int'(big_sel) % 4;
        check("R1 small_out", int'(small_out), ref_small());
        if (tbs) begin
            check("R2 big_out full", int'(big_out), ref_big_at(int'(big_sel)));
            check("R4 tap_lo", int'(tap_lo), ref_big_at(lo_idx));
            check("R4 tap_hi", int'(tap_hi), ref_big_at(4 + lo_idx));
        end else begin
            check("R3 big_out low", int'(big_out), ref_big_at(lo_idx));
            check("R5 tap_lo off", int'(tap_lo), 0);
            check("R5 tap_hi off", int'(tap_hi), 0);
        end
    endtask

    // Drive after a rising edge, sample at the following falling edge
    task automatic step();
        @(negedge clk);
        compare_all();
        @(posedge clk);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stimulus
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Idle pattern: all inputs zero gives all outputs zero (R1, R3, R5)
        @(negedge clk);
        check("R1 idle small_out", int'(small_out), 0);
        check("R3 idle big_out", int'(big_out), 0);
        check("R5 idle taps", int'({tap_hi, tap_lo}), 0);
        @(posedge clk);

        // Random patterns across both modes (R1..R5)
        for (int n = 0; n < 400; n++) begin
            small_data = 4'($urandom);
            small_sel  = 2'($urandom);
            small_inv  = 4'($urandom);
            big_data   = 8'($urandom);
            big_sel    = 3'($urandom);
            big_inv    = 8'($urandom);
            tbs        = 1'($urandom);
            step();
        end

        // R3: top select bit and upper half ignored while mode low
        tbs = 1'b0;
        big_data = 8'b0000_0101;
        big_inv  = 8'b0000_0000;
        for (int s = 0; s < 8; s++) begin
            big_sel = 3'(s);
            big_data[7:4] = 4'($urandom);
            big_inv[7:4]  = 4'($urandom);
            @(negedge clk);
            check("R3 upper ignored", int'(big_out), (5 >> (s % 4)) & 1);
            check("R5 taps held low", int'({tap_hi, tap_lo}), 0);
            @(posedge clk);
        end

        // R6: every three-input function via inversion bits, data tied high
        tbs = 1'b1;
        big_data = 8'hFF;
        for (int f = 0; f < 256; f++) begin
            big_inv = 8'(f);
            for (int s = 0; s < 8; s++) begin
                big_sel = 3'(s);
                @(negedge clk);
                check("R6 lut3", int'(big_out), 1 - ((f >> s) & 1));
                @(posedge clk);
            end
        end

        // R7: every two-input function on the quad selector and on both taps
        small_data = 4'hF;
        for (int f = 0; f < 16; f++) begin
            small_inv = 4'(f);
            big_inv   = {4'(15 - f), 4'(f)};
            for (int s = 0; s < 4; s++) begin
                small_sel = 2'(s);
                big_sel   = 3'(s);
                @(negedge clk);
                check("R7 lut2 small", int'(small_out), 1 - ((f >> s) & 1));
                check("R7 lut2 tap_lo", int'(tap_lo), 1 - ((f >> s) & 1));
                check("R7 lut2 tap_hi", int'(tap_hi), (f >> s) & 1);
                @(posedge clk);
            end
        end

        // R8: flipping an unselected inversion bit changes nothing
        small_data = 4'b1010;
        big_data   = 8'b1100_1010;
        tbs        = 1'b1;
        for (int s = 0; s < 4; s++) begin
            small_sel = 2'(s);
            big_sel   = 3'(s);
            small_inv = '0;
            big_inv   = '0;
            @(negedge clk);
            check("R8 base small", int'(small_out), (10 >> s) & 1);
            @(posedge clk);
            small_inv = ~(4'b1 << s);
            big_inv   = ~(8'b1 << s) & ~(8'b1 << (s + 4));
            @(negedge clk);
            check("R8 small unchanged", int'(small_out), (10 >> s) & 1);
            check("R8 big unchanged", int'(big_out), (8'hCA >> s) & 1);
            check("R8 tap_hi unchanged", int'(tap_hi), (8'hCA >> (s + 4)) & 1);
            @(posedge clk);
            small_inv = 4'b1 << s;
            @(negedge clk);
            check("R8 selected flips", int'(small_out), 1 - ((10 >> s) & 1));
            @(posedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule